// File: doc/BRIEF.md
# Four-Rail Flit Receiver with Per-Channel Credit Return

This block sits at the output port of a router whose links carry flits as four-rail one-hot symbols. Between flits the link rests at an all-zero spacer. The receiver watches the rails, the one-hot virtual-channel wires and the one-hot type wires. It recognises a complete codeword when every symbol position, at least one channel wire and at least one type wire are active. Only then does it capture the flit and convert it back to binary: the kind of flit, the channel index, the two 4-bit coordinates carried by head flits, and the payload bytes.

The captured flit is held on a synchronous valid/ready output. Once the consumer takes it, the receiver raises the credit line of that flit's channel. On the next cycle it raises its acknowledge to the sender. Both lines fall together, but only after two things have happened: the link has gone back to spacer, and the router has answered the credit with that channel's credit acknowledge. A new codeword is taken only while the credit acknowledge of its own channel is low. Malformed symbols, type codes or channel codes set a sticky error flag. A flit that carries one still goes through the full handshake, so the link never locks up.

The rails are treated as inputs synchronous to `clk`. Any synchroniser belongs outside the block.

Top module: `flitReceiver`

## Requirements
- R1: After reset `ackOut`, `creditOut`, `flitValid` and `errorFlag` are all low.
- R2: A codeword is taken only when every symbol position has at least one rail high, `vcIn` is non-zero and `typeIn` is non-zero. A codeword that misses any of these is not accepted, and `flitValid` stays low.
- R3: A symbol at position p is `{rails[3][p],rails[2][p],rails[1][p],rails[0][p]}`. It decodes as 0001→0, 0010→1, 0100→2 and 1000→3. The symbol at position p supplies binary bits [2p+1:2p] of a raw word.
- R4: For a head flit, `flitAddrX` is raw[3:0] (positions 0 and 1) and `flitAddrY` is raw[7:4] (positions 2 and 3). Payload byte k comes from positions 4(k+1) to 4(k+1)+3, and the top payload byte is zero. For data and tail flits the coordinates are zero and `flitData` is the whole raw word.
- R5: `typeIn` 001 gives `flitType` 1 (head), 010 gives 2 (data) and 100 gives 3 (tail). Any other non-zero code gives `flitType` 0.
- R6: `flitVc` is the binary index of the set `vcIn` wire.
- R7: `flitValid` rises on the cycle after acceptance. It stays high, with the flit fields stable, until a cycle in which `flitReady` is high.
- R8: The cycle after `flitReady` is taken, `creditOut` becomes one-hot at `flitVc` while `ackOut` is still low. `ackOut` rises one cycle later.
- R9: `ackOut` and `creditOut` fall together, on the edge after a cycle in which the inputs are at spacer and `creditAckIn[flitVc]` is high. Until then both hold.
- R10: A complete codeword is not accepted while `creditAckIn` of its own channel is high. It is accepted on the edge after that line falls.
- R11: A symbol that is not one-hot, a type code outside R5 or a `vcIn` that is not one-hot sets `errorFlag`. The flag stays set until reset, and the handshake of that flit still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rails | input | 4 x 4*NBYTES | Four rails per symbol position, rails[r][p] |
| vcIn | input | NVC | One-hot channel wires |
| typeIn | input | 3 | One-hot flit type wires |
| ackOut | output | 1 | Four-phase acknowledge to the sender |
| creditOut | output | NVC | Per-channel credit to the router |
| creditAckIn | input | NVC | Per-channel credit acknowledge from the router |
| flitValid | output | 1 | Decoded flit available |
| flitReady | input | 1 | Consumer takes the flit |
| flitType | output | 2 | 0 none/bad, 1 head, 2 data, 3 tail |
| flitVc | output | log2(NVC) | Binary channel index |
| flitAddrX | output | 4 | Head X coordinate |
| flitAddrY | output | 4 | Head Y coordinate |
| flitData | output | 8*NBYTES | Payload |
| errorFlag | output | 1 | Sticky encoding error |

## Verification
Two events can land in the same cycle. First, the return to spacer and the credit acknowledge can arrive together, and only their conjunction may release `ackOut`. The bench first drops the rails while holding the credit acknowledge low, and checks that acknowledge and credit both hold. It then raises the credit acknowledge and expects both to fall on the next edge. Second, a fresh complete codeword can meet a credit acknowledge that is still high for the same channel. The bench presents a new flit before releasing the acknowledge, requires `flitValid` to stay low, and expects acceptance on the edge after the release. A behavioural phase model in the bench predicts `flitValid`, `ackOut` and `creditOut` on every clock.

// File: rtl/flitRxPkg.sv
package flitRxPkg;

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_HEAD = 2'd1,
    FT_DATA = 2'd2,
    FT_TAIL = 2'd3
  } flitKind_t;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_SHOW,
    ST_CRED,
    ST_HOLD
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } rxStrobe_t;

  function automatic logic [1:0] symValue(input logic [3:0] s);
    case (s)
      4'b0010: return 2'd1;
      4'b0100: return 2'd2;
      4'b1000: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic symLegal(input logic [3:0] s);
    return (s == 4'b0001) || (s == 4'b0010) || (s == 4'b0100) || (s == 4'b1000);
  endfunction

endpackage

// File: rtl/flitRxDatapath.sv
module flitRxDatapath
  import flitRxPkg::*;
#(
  parameter int NBYTES = 4,
  parameter int NVC    = 4,
  parameter int VCW    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [3:0][NBYTES*4-1:0] rails,
  input  logic [NVC-1:0]           vcIn,
  input  logic [2:0]               typeIn,
  input  rxStrobe_t                strobe,
  output logic                     complete,
  output logic                     spacer,
  output logic [VCW-1:0]           newVc,
  output logic [1:0]               flitType,
  output logic [VCW-1:0]           flitVc,
  output logic [3:0]               flitAddrX,
  output logic [3:0]               flitAddrY,
  output logic [NBYTES*8-1:0]      flitData,
  output logic                     errorFlag
);

  localparam int SYM = NBYTES * 4;
  localparam int DW  = NBYTES * 8;

  logic [SYM-1:0] posAny;
  logic [SYM-1:0] posBad;
  logic [DW-1:0]  rawWord;

  for (genvar p = 0; p < SYM; p++) begin : g_sym
    logic [3:0] sym;
    assign sym            = {rails[3][p], rails[2][p], rails[1][p], rails[0][p]};
    assign posAny[p]      = |sym;
    assign posBad[p]      = !symLegal(sym);
    assign rawWord[2*p+:2] = symValue(sym);
  end

  assign complete = (&posAny) && (|vcIn) && (|typeIn);
  assign spacer   = (rails == '0) && (vcIn == '0) && (typeIn == '0);

  // lowest set channel wire gives the index
  always_comb begin
    newVc = '0;
    for (int i = NVC - 1; i >= 0; i--) begin
      if (vcIn[i]) newVc = VCW'(i);
    end
  end

  logic vcBad;
  assign vcBad = (vcIn == '0) || ((vcIn & (vcIn - NVC'(1))) != '0);

  flitKind_t kindNow;
  logic      typeBad;
  always_comb begin
    typeBad = 1'b0;
    case (typeIn)
      3'b001:  kindNow = FT_HEAD;
      3'b010:  kindNow = FT_DATA;
      3'b100:  kindNow = FT_TAIL;
      default: begin
        kindNow = FT_NONE;
        typeBad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flitType  <= FT_NONE;
      flitVc    <= '0;
      flitAddrX <= '0;
      flitAddrY <= '0;
      flitData  <= '0;
      errorFlag <= 1'b0;
    end else if (strobe.capture) begin
      flitType <= kindNow;
      flitVc   <= newVc;
      if (kindNow == FT_HEAD) begin
        flitAddrX <= rawWord[3:0];
        flitAddrY <= rawWord[7:4];
        flitData  <= rawWord >> 8;
      end else begin
        flitAddrX <= '0;
        flitAddrY <= '0;
        flitData  <= rawWord;
      end
      errorFlag <= errorFlag | (|posBad) | typeBad | vcBad;
    end
  end

endmodule

// File: rtl/flitRxControl.sv
module flitRxControl
  import flitRxPkg::*;
#(
  parameter int NVC = 4,
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           complete,
  input  logic           spacer,
  input  logic [VCW-1:0] newVc,
  input  logic [VCW-1:0] heldVc,
  input  logic [NVC-1:0] creditAckIn,
  input  logic           flitReady,
  output rxStrobe_t      strobe,
  output logic           flitValid,
  output logic           ackOut,
  output logic [NVC-1:0] creditOut
);

  rxState_t state;

  assign strobe.capture = (state == ST_WAIT) && complete && !creditAckIn[newVc];
  assign flitValid      = (state == ST_SHOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      ackOut    <= 1'b0;
      creditOut <= '0;
    end else begin
      case (state)
        ST_WAIT: if (strobe.capture) state <= ST_SHOW;
        ST_SHOW: if (flitReady) begin
          creditOut <= NVC'(1) << heldVc;
          state     <= ST_CRED;
        end
        ST_CRED: begin
          ackOut <= 1'b1;
          state  <= ST_HOLD;
        end
        ST_HOLD: if (spacer && creditAckIn[heldVc]) begin
          ackOut    <= 1'b0;
          creditOut <= '0;
          state     <= ST_WAIT;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/flitReceiver.sv
module flitReceiver
  import flitRxPkg::*;
#(
  parameter int NBYTES = 4,
  parameter int NVC    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [3:0][NBYTES*4-1:0] rails,
  input  logic [NVC-1:0]           vcIn,
  input  logic [2:0]               typeIn,
  output logic                     ackOut,
  output logic [NVC-1:0]           creditOut,
  input  logic [NVC-1:0]           creditAckIn,
  output logic                     flitValid,
  input  logic                     flitReady,
  output logic [1:0]               flitType,
  output logic [$clog2(NVC)-1:0]   flitVc,
  output logic [3:0]               flitAddrX,
  output logic [3:0]               flitAddrY,
  output logic [NBYTES*8-1:0]      flitData,
  output logic                     errorFlag
);

  localparam int VCW = $clog2(NVC);

  rxStrobe_t      strobe;
  logic           complete;
  logic           spacer;
  logic [VCW-1:0] newVc;

  flitRxDatapath #(.NBYTES(NBYTES), .NVC(NVC), .VCW(VCW)) dp (
    .clk(clk), .rstN(rstN), .rails(rails), .vcIn(vcIn), .typeIn(typeIn),
    .strobe(strobe), .complete(complete), .spacer(spacer), .newVc(newVc),
    .flitType(flitType), .flitVc(flitVc), .flitAddrX(flitAddrX),
    .flitAddrY(flitAddrY), .flitData(flitData), .errorFlag(errorFlag)
  );

  flitRxControl #(.NVC(NVC), .VCW(VCW)) ctl (
    .clk(clk), .rstN(rstN), .complete(complete), .spacer(spacer),
    .newVc(newVc), .heldVc(flitVc), .creditAckIn(creditAckIn),
    .flitReady(flitReady), .strobe(strobe), .flitValid(flitValid),
    .ackOut(ackOut), .creditOut(creditOut)
  );

endmodule

// File: rtl/flitReceiverChk.sv
module flitReceiverChk #(
  parameter int NBYTES = 4,
  parameter int NVC    = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [3:0][NBYTES*4-1:0] rails,
  input logic [NVC-1:0]           vcIn,
  input logic [2:0]               typeIn,
  input logic                     ackOut,
  input logic [NVC-1:0]           creditOut,
  input logic [NVC-1:0]           creditAckIn,
  input logic                     flitValid,
  input logic                     flitReady,
  input logic [$clog2(NVC)-1:0]   flitVc,
  input logic [NBYTES*8-1:0]      flitData,
  input logic                     errorFlag
);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flitValid && !flitReady |=> flitValid && $stable(flitData) && $stable(flitVc));

  // R8
  credit_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(creditOut != '0) && creditOut != '0);

  // R8
  credit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(creditOut));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> creditOut == '0 &&
      $past(rails == '0 && vcIn == '0 && typeIn == '0 && creditAckIn[flitVc]));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errorFlag |=> errorFlag);

endmodule

bind flitReceiver flitReceiverChk #(.NBYTES(NBYTES), .NVC(NVC)) chk (
  .clk(clk), .rstN(rstN), .rails(rails), .vcIn(vcIn), .typeIn(typeIn),
  .ackOut(ackOut), .creditOut(creditOut), .creditAckIn(creditAckIn),
  .flitValid(flitValid), .flitReady(flitReady), .flitVc(flitVc),
  .flitData(flitData), .errorFlag(errorFlag)
);

// File: tb/flitReceiver_test.sv
module flitReceiver_test;
  localparam int NB  = 4;
  localparam int NVC = 4;
  localparam int SYM = NB * 4;
  localparam int DW  = NB * 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [3:0][SYM-1:0]  rails = '0;
  logic [NVC-1:0]       vcIn = '0;
  logic [2:0]           typeIn = '0;
  logic                 ackOut;
  logic [NVC-1:0]       creditOut;
  logic [NVC-1:0]       creditAckIn = '0;
  logic                 flitValid;
  logic                 flitReady = 1'b0;
  logic [1:0]           flitType;
  logic [1:0]           flitVc;
  logic [3:0]           flitAddrX, flitAddrY;
  logic [DW-1:0]        flitData;
  logic                 errorFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit modelOn = 0;

  always #5 clk = ~clk;

  flitReceiver #(.NBYTES(NB), .NVC(NVC)) uut (
    .clk(clk), .rstN(rstN), .rails(rails), .vcIn(vcIn), .typeIn(typeIn),
    .ackOut(ackOut), .creditOut(creditOut), .creditAckIn(creditAckIn),
    .flitValid(flitValid), .flitReady(flitReady), .flitType(flitType),
    .flitVc(flitVc), .flitAddrX(flitAddrX), .flitAddrY(flitAddrY),
    .flitData(flitData), .errorFlag(errorFlag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural phase model: 0 idle, 1 presenting, 2 credit, 3 ack
  int mPhase = 0;
  int mVc = 0;

  function automatic bit inComplete();
    for (int p = 0; p < SYM; p++)
      if (!(rails[0][p] | rails[1][p] | rails[2][p] | rails[3][p])) return 0;
    return (vcIn != 0) && (typeIn != 0);
  endfunction

  function automatic int inVc();
    for (int i = 0; i < NVC; i++) if (vcIn[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else begin
      case (mPhase)
        0: if (inComplete() && !creditAckIn[inVc()]) begin mVc = inVc(); mPhase = 1; end
        1: if (flitReady) mPhase = 2;
        2: mPhase = 3;
        default: if (rails == '0 && vcIn == '0 && typeIn == '0 && creditAckIn[mVc]) mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn && !done) begin
      check("R7 model valid", 64'(flitValid), 64'(mPhase == 1));
      check("R8 model credit", 64'(creditOut), (mPhase >= 2) ? 64'(1 << mVc) : 64'd0);
      check("R9 model ack", 64'(ackOut), 64'(mPhase == 3));
    end
  end

  // encode one flit onto the input wires; kind 1 head, 2 data, 3 tail
  task automatic drive(input int kind, input int vc, input logic [3:0] ax,
                       input logic [3:0] ay, input logic [DW-1:0] d);
    logic [DW-1:0] raw;
    raw = (kind == 1) ? {d[DW-9:0], ay, ax} : d;
    rails = '0;
    for (int p = 0; p < SYM; p++) rails[raw[2*p+:2]][p] = 1'b1;
    typeIn = (kind == 1) ? 3'b001 : (kind == 2) ? 3'b010 : 3'b100;
    vcIn = NVC'(1 << vc);
  endtask

  task automatic toSpacer();
    rails = '0; vcIn = '0; typeIn = '0;
  endtask

  // take presented flit, then complete the handshake on channel vc
  task automatic finish(input int vc);
    flitReady = 1'b1;
    @(negedge clk);
    flitReady = 1'b0;
    check("R8 credit before ack", 64'({ackOut, creditOut}), 64'({1'b0, 4'(1 << vc)}));
    @(negedge clk);
    check("R8 ack after credit", 64'(ackOut), 64'd1);
    toSpacer();
    @(negedge clk);
    @(negedge clk);
    check("R9 hold without credit ack", 64'({ackOut, creditOut}), 64'({1'b1, 4'(1 << vc)}));
    creditAckIn[vc] = 1'b1;
    @(negedge clk);
    check("R9 release", 64'({ackOut, creditOut}), 64'd0);
    creditAckIn[vc] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", 64'({ackOut, creditOut, flitValid, errorFlag}), 64'd0);
    modelOn = 1;

    // head flit, R3 R4 R5 R6
    drive(1, 2, 4'hA, 4'h5, 32'h00C3_7E19);
    @(negedge clk);
    check("R7 valid after accept", 64'(flitValid), 64'd1);
    check("R5 head type", 64'(flitType), 64'd1);
    check("R6 vc index", 64'(flitVc), 64'd2);
    check("R4 addr x", 64'(flitAddrX), 64'hA);
    check("R4 addr y", 64'(flitAddrY), 64'h5);
    check("R3 R4 head payload", 64'(flitData), 64'h00C3_7E19);
    // R7 ready withheld
    repeat (3) @(negedge clk);
    check("R7 valid held", 64'({flitValid, ackOut}), 64'b10);
    finish(2);

    // data flit
    drive(2, 1, 4'h0, 4'h0, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R5 data type", 64'(flitType), 64'd2);
    check("R3 data word", 64'(flitData), 64'hDEAD_BEEF);
    check("R6 vc1", 64'(flitVc), 64'd1);
    finish(1);

    // tail flit on vc3
    drive(3, 3, 4'h0, 4'h0, 32'h1234_5678);
    @(negedge clk);
    check("R5 tail type", 64'(flitType), 64'd3);
    check("R3 tail word", 64'(flitData), 64'h1234_5678);
    check("R4 no coords", 64'({flitAddrX, flitAddrY}), 64'd0);
    check("R11 no error", 64'(errorFlag), 64'd0);
    finish(3);

    // R2 incomplete: position 9 empty, then no vc wire
    drive(2, 0, 4'h0, 4'h0, 32'h0F0F_0F0F);
    for (int r = 0; r < 4; r++) rails[r][9] = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 missing symbol", 64'(flitValid), 64'd0);
    drive(2, 0, 4'h0, 4'h0, 32'h0F0F_0F0F);
    vcIn = '0;
    repeat (3) @(negedge clk);
    check("R2 missing vc", 64'(flitValid), 64'd0);
    vcIn = 4'b0001;
    @(negedge clk);
    check("R2 complete accepted", 64'({flitValid, flitVc}), 64'({1'b1, 2'd0}));
    finish(0);

    // R10 credit ack still high on the same channel
    drive(2, 2, 4'h0, 4'h0, 32'h5555_AAAA);
    creditAckIn[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 blocked by credit ack", 64'(flitValid), 64'd0);
    creditAckIn[2] = 1'b0;
    @(negedge clk);
    check("R10 accepted after release", 64'(flitValid), 64'd1);
    check("R3 word after block", 64'(flitData), 64'h5555_AAAA);
    finish(2);

    // R11 bad symbol: two rails at position 5
    drive(2, 1, 4'h0, 4'h0, 32'h0000_0000);
    rails[1][5] = 1'b1;
    @(negedge clk);
    check("R11 bad symbol valid", 64'(flitValid), 64'd1);
    finish(1);
    check("R11 error set", 64'(errorFlag), 64'd1);

    // R11 bad type code, flag stays, handshake still completes
    drive(2, 0, 4'h0, 4'h0, 32'h0000_1111);
    typeIn = 3'b011;
    @(negedge clk);
    check("R5 bad type code", 64'(flitType), 64'd0);
    finish(0);
    check("R11 error sticky", 64'(errorFlag), 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule